// File: doc/BRIEF.md
# I2C Register-Mapped GPIO Expander

This block is an I2C target that lets a bus master control and observe an 8-bit general-purpose I/O port. The port is configured and read through eight byte-wide registers. A command byte sent after the target address loads a register pointer. Later data bytes are written to that register or read from it, and the pointer steps forward after each byte.

The bus lines are sampled with the system clock. The block pulls SDA low through a registered open-drain control. On the pin side it reads an 8-bit input bus and produces a registered output value and a registered per-pin output enable. The register set covers:

- the live input level, passed through a per-pin polarity mask;
- bus-hold and pull-select bytes, which are stored only for circuits outside the block;
- a direction byte;
- the output value;
- an event mask;
- a sticky change-status byte that clears when it is read.

Top module: `gpx_expander`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the parameter DEV_ADDR (default 7'h20). Any other address gets no acknowledge, and the command and data bytes that follow it change no register or output.
- R2: In a write transfer (address with bit 0 = 0, then a command byte, then a data byte), the data byte is stored in the selected register on the SCL falling edge that ends its acknowledge bit. Register 5 drives `pins_out`.
- R3: Only command bits [2:0] select the register. Bits [7:3] of the command byte are ignored.
- R4: A read transfer sends the address with bit 0 = 0 and the command byte, then a repeated start and the address with bit 0 = 1. The target then returns the selected register, most significant bit first. The target never pulls SDA during the acknowledge bit that the master drives, and the pointer is kept between transfers.
- R5: During a read, the pointer advances by one after each byte the target sends. It wraps from 7 to 0.
- R6: Several data bytes in one write transfer go to consecutive registers, because the pointer also advances after each byte written.
- R7: Register 0 reads back the synchronized pin inputs XOR register 1 (polarity). The value does not depend on register 4.
- R8: Registers 0 and 7 are read-only. Writes to them are acknowledged but change nothing.
- R9: `pins_oe[i]` is the inverse of register 4 bit i, where 1 means input and 0 means drive. `pins_out` follows register 5.
- R10: Register 7 bit i is set when pin i changes level while register 6 bit i is 0. A 1 in register 6 masks the pin. Reading register 7 clears it.
- R11: A start or stop condition at any point abandons the byte in progress, and a partly received data byte is never written.
- R12: After reset the registers read as follows: 1, 2, 3 and 5 = 00h; 4 and 6 = FFh; 7 = 00h. `pins_out` and `pins_oe` are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Bus clock line level |
| sda | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the SDA line low (open drain) |
| pins_in | input | 8 | Levels present on the port pins |
| pins_out | output | 8 | Value the pins drive when enabled |
| pins_oe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The bench acts as an open-drain bus master. Its read tests use several access patterns:

- A read that starts at register 1 and runs across the wrap separates the reset values of each register and exposes a pointer that fails to increment or to wrap.
- A read from the kept pointer, with no command byte, shows whether the pointer survives a repeated start.
- Writes of single bytes, of several bytes and of a command with its upper bits set, each read back or observed on `pins_out` and `pins_oe`, tell register selection apart from auto-increment.
- Transfers cut off by a stop or a repeated start in the middle of a byte, and an address that does not match, show whether the target state machine aborts and whether it wrongly acknowledges.

Pin changes are applied with the mask both set and clear, then read twice, to separate setting the status from clearing it on read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PORT_W    = 8;
  localparam int REG_COUNT = 8;
  localparam int IDX_W     = $clog2(REG_COUNT);

  typedef enum logic [IDX_W-1:0] {
    RG_INPUT    = 3'd0,
    RG_POLARITY = 3'd1,
    RG_HOLD     = 3'd2,
    RG_PULLSEL  = 3'd3,
    RG_DIR      = 3'd4,
    RG_OUTPUT   = 3'd5,
    RG_MASK     = 3'd6,
    RG_STATUS   = 3'd7
  } reg_idx_e;

  typedef enum logic [3:0] {
    LK_IDLE, LK_ADDR, LK_ADDR_ACK, LK_CMD, LK_CMD_ACK,
    LK_WDATA, LK_WDATA_ACK, LK_RDATA, LK_RACK
  } link_state_e;

  function automatic logic is_writable(input logic [IDX_W-1:0] idx);
    return !(idx == RG_INPUT || idx == RG_STATUS);
  endfunction

  function automatic logic [PORT_W-1:0] reset_value(input logic [IDX_W-1:0] idx);
    case (idx)
      RG_DIR, RG_MASK: return '1;
      default:         return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpx_bus_sync.sv
module gpx_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/gpx_link.sv
module gpx_link
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [PORT_W-1:0]   rd_data,
  output logic                sda_pull,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [PORT_W-1:0]   wr_data,
  output logic                rd_en,
  output logic [IDX_W-1:0]    rd_idx
);
  localparam int CNT_W = $clog2(PORT_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(PORT_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(PORT_W - 1);

  link_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PORT_W-1:0] rx_q, tx_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              rw_q, nack_q, pull_q;

  // a new byte is fetched on the falling edge that ends the acknowledge bit
  assign rd_en  = scl_fall && !start_det && !stop_det &&
                  ((state_q == LK_ADDR_ACK && rw_q) || (state_q == LK_RACK && !nack_q));
  assign rd_idx   = ptr_q;
  assign sda_pull = pull_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state_q <= LK_IDLE;
        pull_q  <= 1'b0;
      end else if (start_det) begin
        state_q <= LK_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        case (state_q)
          LK_ADDR, LK_CMD, LK_WDATA: begin
            if (scl_rise && cnt_q != LAST_RX) begin
              rx_q  <= {rx_q[PORT_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST_RX) begin
              cnt_q <= '0;
              if (state_q == LK_ADDR) begin
                if (rx_q[7:1] == DEV_ADDR) begin
                  pull_q  <= 1'b1;
                  rw_q    <= rx_q[0];
                  state_q <= LK_ADDR_ACK;
                end else begin
                  state_q <= LK_IDLE;
                end
              end else begin
                pull_q  <= 1'b1;
                state_q <= (state_q == LK_CMD) ? LK_CMD_ACK : LK_WDATA_ACK;
              end
            end
          end
          LK_ADDR_ACK: if (scl_fall) begin
            if (rw_q) begin
              tx_q    <= rd_data;
              pull_q  <= ~rd_data[PORT_W-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= LK_RDATA;
            end else begin
              pull_q  <= 1'b0;
              state_q <= LK_CMD;
            end
          end
          LK_CMD_ACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            ptr_q   <= rx_q[IDX_W-1:0];
            state_q <= LK_WDATA;
          end
          LK_WDATA_ACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            wr_en   <= 1'b1;
            wr_idx  <= ptr_q;
            wr_data <= rx_q;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= LK_WDATA;
          end
          LK_RDATA: if (scl_fall) begin
            if (cnt_q == LAST_TX) begin
              cnt_q   <= '0;
              pull_q  <= 1'b0;
              state_q <= LK_RACK;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              tx_q   <= {tx_q[PORT_W-2:0], 1'b0};
              pull_q <= ~tx_q[PORT_W-2];
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= LK_IDLE;
              end else begin
                tx_q    <= rd_data;
                pull_q  <= ~rd_data[PORT_W-1];
                ptr_q   <= ptr_q + 1'b1;
                state_q <= LK_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_addr_match_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_ADDR_ACK) |-> (rx_q[7:1] == DEV_ADDR));

  p_master_ack_free_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_RACK) |-> !sda_pull);

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state_q == LK_IDLE && !sda_pull));
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins_in,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] pins_out,
  output logic [PORT_W-1:0] pins_oe
);
  logic [PORT_W-1:0] bank [REG_COUNT];
  logic [PORT_W-1:0] pin_s1, pin_s2, pin_prev, status_q, events;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= reset_value(IDX_W'(i));
    end else if (wr_en && is_writable(wr_idx)) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign events = (pin_s2 ^ pin_prev) & ~bank[RG_MASK];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s1   <= '0;
      pin_s2   <= '0;
      pin_prev <= '0;
      status_q <= '0;
      pins_out <= '0;
      pins_oe  <= '0;
    end else begin
      pin_s1   <= pins_in;
      pin_s2   <= pin_s1;
      pin_prev <= pin_s2;
      // an event arriving in the read cycle survives the clear
      if (rd_en && rd_idx == RG_STATUS) status_q <= events;
      else                              status_q <= status_q | events;
      pins_out <= bank[RG_OUTPUT];
      pins_oe  <= ~bank[RG_DIR];
    end
  end

  always_comb begin
    case (rd_idx)
      RG_INPUT:  rd_data = pin_s2 ^ bank[RG_POLARITY];
      RG_STATUS: rd_data = status_q;
      default:   rd_data = bank[rd_idx];
    endcase
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_writable(wr_idx)) |=> (bank[$past(wr_idx)] == $past(wr_data)));

  p_status_masked_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & ~$past(status_q) & $past(bank[RG_MASK])) == '0));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_pull,
  input  logic [PORT_W-1:0] pins_in,
  output logic [PORT_W-1:0] pins_out,
  output logic [PORT_W-1:0] pins_oe
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, rd_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [PORT_W-1:0] wr_data, rd_data;

  gpx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  gpx_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_pull(sda_pull), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx)
  );

  gpx_regs u_regs (
    .clk(clk), .rst(rst), .pins_in(pins_in), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .pins_out(pins_out), .pins_oe(pins_oe)
  );
endmodule

// File: tb/gpx_expander_test.sv
`timescale 1ns/1ps
module gpx_expander_test;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h40;
  localparam logic [7:0] AR = 8'h41;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_pull;
  logic [7:0] pins_in = 8'hA5;
  logic [7:0] pins_out, pins_oe;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  gpx_expander uut (
    .clk(clk), .rst(rst), .scl(scl_m), .sda(sda_bus), .sda_pull(sda_pull),
    .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [7:0] o;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) check("scoreboard underflow", o, 8'hxx);
        else check(tag_q.pop_front(), o, exp_q.pop_front());
      end
    end
  end

  task automatic waitq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; waitq(); scl_m = 1; waitq(); sda_m = 0; waitq(); scl_m = 0; waitq(); endtask
  task automatic bus_stop(); sda_m = 0; waitq(); scl_m = 1; waitq(); sda_m = 1; waitq(); endtask
  task automatic send_bit(input logic b); sda_m = b; waitq(); scl_m = 1; waitq(); waitq(); scl_m = 0; waitq(); endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; waitq(); scl_m = 1; waitq();
    acked = !sda_bus;
    waitq(); scl_m = 0; waitq();
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); scl_m = 1; waitq(); b[i] = sda_bus; waitq(); scl_m = 0;
    end
    send_bit(last);
    sda_m = 1;
  endtask

  task automatic write_regs(input string tag, input logic [7:0] cmd, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(AW, a);  check({tag, " addr ack"}, {7'd0, a}, 8'd1);
    send_byte(cmd, a); check({tag, " cmd ack"}, {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); check({tag, " data ack"}, {7'd0, a}, 8'd1);
    end
    bus_stop();
    waitq();
  endtask

  task automatic read_bytes(input int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      obs_q.push_back(b);
    end
    bus_stop();
    waitq();
  endtask

  task automatic read_regs(input logic [7:0] cmd, input int n);
    logic a;
    bus_start();
    send_byte(AW, a);  check("R4 write addr ack", {7'd0, a}, 8'd1);
    send_byte(cmd, a); check("R4 cmd ack", {7'd0, a}, 8'd1);
    bus_start();
    send_byte(AR, a);  check("R4 read addr ack", {7'd0, a}, 8'd1);
    read_bytes(n);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    repeat (10) @(negedge clk);
    rst = 0;
    repeat (10) @(negedge clk);
    check("R12 pins_out after reset", pins_out, 8'h00);
    check("R12 pins_oe after reset", pins_oe, 8'h00);

    // R12 reset values, R5 pointer wraps from 7 to 0 onto the input register
    expect_byte("R12 polarity", 8'h00);
    expect_byte("R12 hold", 8'h00);
    expect_byte("R12 pull select", 8'h00);
    expect_byte("R12 direction", 8'hFF);
    expect_byte("R12 output", 8'h00);
    expect_byte("R12 mask", 8'hFF);
    expect_byte("R12 status", 8'h00);
    expect_byte("R5 wrap to input", 8'hA5);
    read_regs(8'h01, 8);

    write_regs("R2", 8'h05, 1, 8'h3C, 8'h00, 8'h00);
    check("R2 output register on pins", pins_out, 8'h3C);
    write_regs("R9", 8'h04, 1, 8'h0F, 8'h00, 8'h00);
    check("R9 enable is inverted direction", pins_oe, 8'hF0);
    check("R9 output kept", pins_out, 8'h3C);

    write_regs("R3", 8'hF5, 1, 8'hC3, 8'h00, 8'h00);
    check("R3 upper command bits ignored", pins_out, 8'hC3);

    write_regs("R6", 8'h01, 3, 8'h11, 8'h22, 8'h33);
    expect_byte("R6 first", 8'h11);
    expect_byte("R6 second", 8'h22);
    expect_byte("R6 third", 8'h33);
    read_regs(8'h01, 3);

    expect_byte("R7 input xor polarity", 8'hB4);
    read_regs(8'h00, 1);
    pins_in = 8'h5A;
    waitq();
    expect_byte("R7 input after pin change", 8'h4B);
    read_regs(8'h00, 1);

    // R4 pointer kept: last read used register 0, so the next is register 1
    bus_start();
    send_byte(AR, a); check("R4 direct read ack", {7'd0, a}, 8'd1);
    expect_byte("R4 kept pointer", 8'h11);
    read_bytes(1);

    write_regs("R8", 8'h07, 2, 8'h99, 8'h66, 8'h00);
    expect_byte("R8 status unchanged", 8'h00);
    expect_byte("R8 input unchanged", 8'h4B);
    read_regs(8'h07, 2);

    // R1 foreign address
    bus_start();
    send_byte(8'h42, a); check("R1 foreign address nack", {7'd0, a}, 8'd0);
    send_byte(8'h05, a); check("R1 command ignored", {7'd0, a}, 8'd0);
    send_byte(8'h00, a);
    bus_stop();
    waitq();
    check("R1 output unchanged", pins_out, 8'hC3);

    // R11 stop inside a data byte
    bus_start();
    send_byte(AW, a);
    send_byte(8'h05, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    waitq();
    check("R11 stop aborts write", pins_out, 8'hC3);

    // R11 repeated start inside a data byte, then read the same register
    bus_start();
    send_byte(AW, a);
    send_byte(8'h05, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_byte(AR, a); check("R11 restart address ack", {7'd0, a}, 8'd1);
    expect_byte("R11 register intact", 8'hC3);
    read_bytes(1);
    check("R11 pins intact", pins_out, 8'hC3);

    // R10 status with low nibble unmasked: bits 0 and 4 change, only bit 0 counts
    write_regs("R10", 8'h06, 1, 8'hF0, 8'h00, 8'h00);
    pins_in = 8'h4B;
    waitq();
    expect_byte("R10 status set", 8'h01);
    read_regs(8'h07, 1);
    expect_byte("R10 status cleared by read", 8'h00);
    read_regs(8'h07, 1);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule